// File: doc/BRIEF.md
# Seconds and Alarm Real-Time Counter

This block keeps time in two cascaded stages. A seconds stage counts ticks from a chosen timing source. When it reaches a programmable reload value it returns to zero and emits a one-second event. An alarm stage counts those events. It raises an alarm flag when it reaches a programmable alarm value and then starts again from zero. If it rolls past its largest value without a match, it raises an overflow flag instead.

Three timing sources are offered: a low-speed RC tick, a low-speed crystal tick, and a high-speed crystal tick divided by a parameterised ratio (128 by default). Each source arrives as a single-cycle enable pulse in the system clock domain. Software reaches the block through a simple write and read register port. That port carries the run enable, the source choice, the interrupt enables, sticky flags cleared by writing ones, the reload and alarm values, and the live values of both counters. A level interrupt combines the flags with their enables.

Register addresses on `wrAddr`/`rdAddr` are as follows:

| Address | Contents |
|---|---|
| 0 | run enable (bit 0) |
| 1 | source select (bits 1:0) |
| 2 | interrupt enables (bits 2:0) |
| 3 | flags |
| 4 | seconds reload value |
| 5 | alarm value |
| 6 | seconds count, read only |
| 7 | alarm count, read only |

The flag bits are: bit 0 second, bit 1 alarm, bit 2 overflow.

Top module: `rtc_core`

## Requirements
- R1: After reset the reload register reads 0x8000, both counts read 0, the flags read 0, the run enable reads 0 and `irq` is low.
- R2: While running, each selected tick moves the seconds count up by one. A tick that finds the count equal to the reload value returns it to 0 and sets flag bit 0. With reload 3 the count reads 1, 2, 3, 0 over four ticks.
- R3: Each second event raises the alarm count by one. A second event that finds the count equal to the alarm value returns it to 0 and sets flag bit 1.
- R4: A flag stays set until a write to address 3 carries a 1 in its bit position. Writing 0 to a flag bit has no effect on it.
- R5: `irq` is high exactly when some flag bit is set together with the same bit of the enable register at address 2.
- R6: With run enable 0, source ticks leave both counts and the high-speed divider unchanged.
- R7: Source code 00 takes ticks from `lrcTickEn` and code 01 from `lxtalTickEn`. Pulses on the unselected inputs have no effect.
- R8: Source code 11 advances the seconds count once per 128 `hxtalTickEn` pulses.
- R9: Source code 10 is reserved; no input advances the counts under it.
- R10: Any write to address 1 returns both counts and the divider to 0.
- R11: Any write to address 4 returns both counts and the divider to 0.
- R12: A second event that finds the alarm count at its all-ones value without an alarm match returns it to 0 and sets flag bit 2 but not bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lrcTickEn | input | 1 | Low-speed RC tick pulse |
| lxtalTickEn | input | 1 | Low-speed crystal tick pulse |
| hxtalTickEn | input | 1 | High-speed crystal tick pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench goes after the wrap point of each stage. A design that compares against reload plus one, or wraps one tick early, breaks the 1, 2, 3, 0 sequence or puts the alarm on the wrong event. It drives every source input under every source code. A wrongly decoded select or a missing reserved case then shows up as counts that move under the wrong source. It also checks the divide-by-128 boundary at pulses 127 and 128, which catches an off-by-one divider. Finally, it lowers the alarm value below a running count to force a roll-over. A design that confuses overflow with alarm, or fails to reset counts on configuration writes, shows the wrong flag or stale counts.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL   = 3'd0,
    ADDR_SRC    = 3'd1,
    ADDR_IE     = 3'd2,
    ADDR_FLAGS  = 3'd3,
    ADDR_RELOAD = 3'd4,
    ADDR_ALARM  = 3'd5,
    ADDR_SEC    = 3'd6,
    ADDR_ALM    = 3'd7
  } regAddrE;

  typedef enum logic [1:0] {
    SRC_LRC   = 2'b00,
    SRC_LXTAL = 2'b01,
    SRC_RSVD  = 2'b10,
    SRC_HXTAL = 2'b11
  } srcSelE;

  localparam int NUM_FLAGS = 3;

  typedef struct packed {
    logic tick;
    logic clear;
  } dpStrobeT;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl import rtc_pkg::*; #(
  parameter int SEC_W      = 20,
  parameter int ALM_W      = 32,
  parameter int DATA_W     = 32,
  parameter int DIV        = 128,
  parameter int RELOAD_RST = 'h8000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lrcTickEn,
  input  logic                 lxtalTickEn,
  input  logic                 hxtalTickEn,
  input  logic                 wrEn,
  input  logic [2:0]           wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [2:0]           rdAddr,
  output logic [DATA_W-1:0]    rdData,
  input  logic [SEC_W-1:0]     secCnt,
  input  logic [ALM_W-1:0]     almCnt,
  input  logic                 secEvent,
  input  logic                 almEvent,
  input  logic                 ovfEvent,
  output dpStrobeT             strobe,
  output logic [SEC_W-1:0]     reloadVal,
  output logic [ALM_W-1:0]     alarmVal,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 runEn,
  output logic                 irq
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

  logic [1:0]           srcSel;
  logic [NUM_FLAGS-1:0] ieQ;
  logic [DIV_W-1:0]     divCnt;
  logic                 cfgWrite;
  logic                 srcPulse;
  logic                 hxtalRun;
  logic [NUM_FLAGS-1:0] clrMask;

  assign cfgWrite = wrEn && ((wrAddr == ADDR_SRC) || (wrAddr == ADDR_RELOAD));
  assign clrMask  = (wrEn && wrAddr == ADDR_FLAGS) ? wrData[NUM_FLAGS-1:0] : '0;
  assign hxtalRun = runEn && hxtalTickEn && (srcSel == SRC_HXTAL);

  always_comb begin
    case (srcSel)
      SRC_LRC:   srcPulse = lrcTickEn;
      SRC_LXTAL: srcPulse = lxtalTickEn;
      SRC_HXTAL: srcPulse = hxtalTickEn && (divCnt == DIV_LAST);
      default:   srcPulse = 1'b0;
    endcase
  end

  assign strobe.clear = cfgWrite;
  assign strobe.tick  = runEn && srcPulse && !cfgWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (cfgWrite) begin
      divCnt <= '0;
    end else if (hxtalRun) begin
      divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      srcSel    <= SRC_LRC;
      ieQ       <= '0;
      reloadVal <= SEC_W'(RELOAD_RST);
      alarmVal  <= '1;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL:   runEn     <= wrData[0];
        ADDR_SRC:    srcSel    <= wrData[1:0];
        ADDR_IE:     ieQ       <= wrData[NUM_FLAGS-1:0];
        ADDR_RELOAD: reloadVal <= wrData[SEC_W-1:0];
        ADDR_ALARM:  alarmVal  <= wrData[ALM_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrMask) | {ovfEvent, almEvent, secEvent};
  end

  assign irq = |(flags & ieQ);

  always_comb begin
    case (rdAddr)
      ADDR_CTRL:   rdData = DATA_W'(runEn);
      ADDR_SRC:    rdData = DATA_W'(srcSel);
      ADDR_IE:     rdData = DATA_W'(ieQ);
      ADDR_FLAGS:  rdData = DATA_W'(flags);
      ADDR_RELOAD: rdData = DATA_W'(reloadVal);
      ADDR_ALARM:  rdData = DATA_W'(alarmVal);
      ADDR_SEC:    rdData = DATA_W'(secCnt);
      default:     rdData = DATA_W'(almCnt);
    endcase
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath import rtc_pkg::*; #(
  parameter int SEC_W = 20,
  parameter int ALM_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic [SEC_W-1:0] reloadVal,
  input  logic [ALM_W-1:0] alarmVal,
  output logic [SEC_W-1:0] secCnt,
  output logic [ALM_W-1:0] almCnt,
  output logic             secEvent,
  output logic             almEvent,
  output logic             ovfEvent
);
  logic almMatch;
  logic almFull;

  assign secEvent = strobe.tick && (secCnt == reloadVal);
  assign almMatch = (almCnt == alarmVal);
  assign almFull  = &almCnt;
  assign almEvent = secEvent && almMatch;
  assign ovfEvent = secEvent && !almMatch && almFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secCnt <= '0;
      almCnt <= '0;
    end else if (strobe.clear) begin
      secCnt <= '0;
      almCnt <= '0;
    end else if (strobe.tick) begin
      secCnt <= secEvent ? '0 : secCnt + 1'b1;
      if (secEvent) almCnt <= (almMatch || almFull) ? '0 : almCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_core.sv
module rtc_core import rtc_pkg::*; #(
  parameter int SEC_W      = 20,
  parameter int ALM_W      = 32,
  parameter int DATA_W     = 32,
  parameter int DIV        = 128,
  parameter int RELOAD_RST = 'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lrcTickEn,
  input  logic              lxtalTickEn,
  input  logic              hxtalTickEn,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  dpStrobeT             strobe;
  logic [SEC_W-1:0]     secCnt;
  logic [ALM_W-1:0]     almCnt;
  logic [SEC_W-1:0]     reloadVal;
  logic [ALM_W-1:0]     alarmVal;
  logic [NUM_FLAGS-1:0] flags;
  logic                 runEn;
  logic                 secEvent;
  logic                 almEvent;
  logic                 ovfEvent;

  rtc_ctrl #(
    .SEC_W(SEC_W), .ALM_W(ALM_W), .DATA_W(DATA_W), .DIV(DIV), .RELOAD_RST(RELOAD_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .lrcTickEn(lrcTickEn), .lxtalTickEn(lxtalTickEn), .hxtalTickEn(hxtalTickEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .secCnt(secCnt), .almCnt(almCnt),
    .secEvent(secEvent), .almEvent(almEvent), .ovfEvent(ovfEvent),
    .strobe(strobe), .reloadVal(reloadVal), .alarmVal(alarmVal),
    .flags(flags), .runEn(runEn), .irq(irq)
  );

  rtc_datapath #(.SEC_W(SEC_W), .ALM_W(ALM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reloadVal(reloadVal), .alarmVal(alarmVal),
    .secCnt(secCnt), .almCnt(almCnt),
    .secEvent(secEvent), .almEvent(almEvent), .ovfEvent(ovfEvent)
  );
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int SEC_W  = 20,
  parameter int ALM_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irq,
  input logic [SEC_W-1:0]  secCnt,
  input logic [ALM_W-1:0]  almCnt,
  input logic [SEC_W-1:0]  reloadVal,
  input logic [2:0]        flags,
  input logic              runEn
);
  logic       cfgWr;
  logic [2:0] clrMask;
  logic [2:0] keepMask;

  assign cfgWr    = wrEn && (wrAddr == 3'd1 || wrAddr == 3'd4);
  assign clrMask  = (wrEn && wrAddr == 3'd3) ? wrData[2:0] : 3'b000;
  assign keepMask = flags & ~clrMask;

  assert_sec_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    secCnt <= reloadVal);

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (secCnt == $past(secCnt)) || (secCnt == '0) ||
             (secCnt == $past(secCnt) + SEC_W'(1)));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((flags & $past(keepMask)) == $past(keepMask)));

  assert_irq_src_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != 3'b000));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !cfgWr) |=> ($stable(secCnt) && $stable(almCnt)));

  // covers R10 and R11
  assert_cfg_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (secCnt == '0 && almCnt == '0));
endmodule

bind rtc_core rtc_core_chk #(.SEC_W(SEC_W), .ALM_W(ALM_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irq(irq), .secCnt(secCnt), .almCnt(almCnt), .reloadVal(reloadVal),
  .flags(flags), .runEn(runEn)
);

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lrcTickEn = 1'b0, lxtalTickEn = 1'b0, hxtalTickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        irq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  rtc_core #(.ALM_W(8)) u_dut (
    .clk(clk), .rstN(rstN), .lrcTickEn(lrcTickEn), .lxtalTickEn(lxtalTickEn),
    .hxtalTickEn(hxtalTickEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rdAddr = a; #0.5; d = rdData;
  endtask

  task automatic ticks(int which, int n);
    case (which) 0: lrcTickEn = 1'b1; 1: lxtalTickEn = 1'b1; default: hxtalTickEn = 1'b1; endcase
    repeat (n) @(negedge clk);
    lrcTickEn = 1'b0; lxtalTickEn = 1'b0; hxtalTickEn = 1'b0;
  endtask

  task automatic chkReg(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v); check(req, v, exp);
  endtask

  task automatic testReset();
    chkReg("R1 reload", 3'd4, 32'h8000);
    chkReg("R1 sec", 3'd6, 0);
    chkReg("R1 alm", 3'd7, 0);
    chkReg("R1 flags", 3'd3, 0);
    chkReg("R1 run", 3'd0, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic testSecSeq();
    wr(3'd0, 1); wr(3'd4, 3);
    ticks(0, 1); chkReg("R2 seq1", 3'd6, 1);
    ticks(0, 1); chkReg("R2 seq2", 3'd6, 2);
    ticks(0, 1); chkReg("R2 seq3", 3'd6, 3);
    chkReg("R2 no flag yet", 3'd3, 0);
    ticks(0, 1); chkReg("R2 seq0", 3'd6, 0);
    chkReg("R2 sec flag", 3'd3, 1);
    chkReg("R2 alm count", 3'd7, 1);
  endtask

  task automatic testAlarm();
    wr(3'd3, 7); wr(3'd5, 2); wr(3'd4, 1);
    ticks(0, 4);
    chkReg("R3 alm before", 3'd7, 2);
    chkReg("R3 no alarm", 3'd3, 1);
    ticks(0, 2);
    chkReg("R3 alm wrap", 3'd7, 0);
    chkReg("R3 alarm flag", 3'd3, 3);
  endtask

  task automatic testW1c();
    wr(3'd3, 2); chkReg("R4 clear alarm only", 3'd3, 1);
    wr(3'd3, 0); chkReg("R4 zero no effect", 3'd3, 1);
    wr(3'd3, 1); chkReg("R4 clear sec", 3'd3, 0);
  endtask

  task automatic testIrq();
    wr(3'd2, 0); ticks(0, 2);
    chkReg("R5 flag", 3'd3, 1);
    check("R5 masked", {31'd0, irq}, 0);
    wr(3'd2, 1); check("R5 enabled", {31'd0, irq}, 1);
    wr(3'd2, 2); check("R5 other enable", {31'd0, irq}, 0);
    wr(3'd2, 1); wr(3'd3, 1); check("R5 cleared", {31'd0, irq}, 0);
    wr(3'd2, 0);
  endtask

  task automatic testFreeze();
    logic [31:0] s, a;
    wr(3'd4, 100); ticks(0, 7);
    rd(3'd6, s); rd(3'd7, a);
    check("R6 pre", s, 7);
    wr(3'd0, 0); ticks(0, 10);
    chkReg("R6 sec frozen", 3'd6, s);
    chkReg("R6 alm frozen", 3'd7, a);
    wr(3'd0, 1); ticks(0, 1);
    chkReg("R6 resumes", 3'd6, 8);
  endtask

  task automatic testSource();
    wr(3'd1, 1);
    ticks(0, 5); chkReg("R7 lrc ignored", 3'd6, 0);
    ticks(1, 5); chkReg("R7 lxtal counts", 3'd6, 5);
    ticks(2, 5); chkReg("R7 hxtal ignored", 3'd6, 5);
    wr(3'd1, 0);
    ticks(1, 3); chkReg("R7 lxtal ignored", 3'd6, 0);
    ticks(0, 3); chkReg("R7 lrc counts", 3'd6, 3);
  endtask

  task automatic testCfgClear();
    wr(3'd1, 1); wr(3'd5, 200); wr(3'd4, 1);
    ticks(1, 7);
    chkReg("R10 pre sec", 3'd6, 1);
    chkReg("R10 pre alm", 3'd7, 3);
    wr(3'd1, 1);
    chkReg("R10 sec cleared", 3'd6, 0);
    chkReg("R10 alm cleared", 3'd7, 0);
    ticks(1, 7);
    wr(3'd4, 1);
    chkReg("R11 sec cleared", 3'd6, 0);
    chkReg("R11 alm cleared", 3'd7, 0);
  endtask

  task automatic testHxtal();
    wr(3'd1, 3); wr(3'd4, 100);
    ticks(2, 127); chkReg("R8 127 pulses", 3'd6, 0);
    ticks(2, 1);   chkReg("R8 128 pulses", 3'd6, 1);
    ticks(2, 128); chkReg("R8 256 pulses", 3'd6, 2);
  endtask

  task automatic testReserved();
    wr(3'd1, 2);
    ticks(0, 50); ticks(1, 50); ticks(2, 200);
    chkReg("R9 reserved no count", 3'd6, 0);
  endtask

  task automatic testOverflow();
    logic [31:0] f;
    wr(3'd1, 0); wr(3'd5, 200); wr(3'd4, 0);
    ticks(0, 10); chkReg("R12 pre", 3'd7, 10);
    wr(3'd3, 7); wr(3'd5, 5);
    ticks(0, 245);
    chkReg("R12 at max", 3'd7, 255);
    rd(3'd3, f); check("R12 no ovf yet", {31'd0, f[2]}, 0);
    ticks(0, 1);
    chkReg("R12 wrapped", 3'd7, 0);
    rd(3'd3, f); check("R12 ovf not alarm", {30'd0, f[2:1]}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSecSeq();
    testAlarm();
    testW1c();
    testIrq();
    testFreeze();
    testSource();
    testCfgClear();
    testHxtal();
    testReserved();
    testOverflow();
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule